// File: doc/BRIEF.md
# Cache-Line Atomic Swap Unit

This unit carries out one read-modify-write on a word of up to eight bytes inside a single cache line. A requester hands over the whole line, a byte offset, an access size, a write value and, for the conditional form, a compare value. The unit pulls the addressed bytes out of the line, decides whether to write, and drives a full-line write port with byte enables and a dirty-mark strobe. It then returns the bytes that were there before, whether or not a write took place.

Tag lookup, hit detection and permission checks happen elsewhere. The caller invokes the unit only on a line it already holds writable.

Requests arrive over a valid/ready handshake. The write cycle follows one cycle after acceptance, and the response follows one cycle after that. Only one operation is in flight at a time. A parameter can remove conditional support. With that option set, every conditional request is rejected.

Top module: `line_swap_unit`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1, `rsp_valid` is 0 and `lw_en` is 0.
- R2: A request is taken on a clock edge with `req_valid` and `req_ready` both high. `lw_en` can pulse only in the next cycle, and `rsp_valid` rises in the cycle after that. `req_ready` stays 0 from the accept until the edge on which `rsp_valid` and `rsp_ready` are both high, so no request offered in that window is taken.
- R3: For an accepted request, `rsp_old` byte k (bits 8k+7..8k) equals line byte `offset+k` for every k below `req_size`. The bytes are little-endian, line byte b sits at bits 8b+7..8b, and bytes at or above the size read as zero. This holds whether or not a write occurs.
- R4: When `req_cond` is 0 the swap is unconditional. A legal unconditional request pulses `lw_en` once. `lw_be` bit b is set for `offset <= b < offset+size`. `lw_data` byte b equals `req_wdata` byte `b-offset` inside that window and the original line byte outside it. `rsp_wrote` is 1.
- R5: When `req_cond` is 1 the swap is conditional. A size of 4 compares only bits 31..0 of `req_cmp` with the old word; a size of 8 compares all 64 bits. The write of R4 happens only on equality, and `rsp_wrote` reports whether it happened.
- R6: A conditional request with any size other than 4 or 8 sets `rsp_err`. It causes no write, and `rsp_old` is zero.
- R7: A size of 0, a size above 8, or `offset+size` above the line length sets `rsp_err`. It causes no write, and `rsp_old` is zero.
- R8: `lw_mark_dirty` is high in exactly the cycles where `lw_en` is high.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_old`, `rsp_err` and `rsp_wrote` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_cond | input | 1 | 1 = conditional swap, 0 = unconditional |
| req_offset | input | clog2(LINE_BYTES) | Byte offset of the word in the line |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Value to store, little-endian |
| req_cmp | input | 64 | Compare value for the conditional form |
| req_line | input | 8*LINE_BYTES | Current line contents |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_old | output | 64 | Prior contents of the addressed bytes |
| rsp_wrote | output | 1 | The line was written |
| rsp_err | output | 1 | Illegal size, range or conditional size |
| lw_en | output | 1 | Line write strobe |
| lw_be | output | LINE_BYTES | Byte enables of the line write |
| lw_data | output | 8*LINE_BYTES | Merged line data |
| lw_mark_dirty | output | 1 | Mark the written line dirty |

## Verification
The bench sweeps every offset of a 16-byte line against every size from 0 to 9. Each pair runs as an unconditional swap, a conditional swap whose compare matches, and a conditional swap whose compare misses. A 4-byte match carries garbage in the upper compare half, so a design that compared all 64 bits would wrongly refuse those writes. A design with an off-by-one on the line end would either write past the line or reject the last legal word, and the offsets near 15 expose both. A design that dropped the old value on a failed compare, or wrote on an illegal conditional size, would fail the per-byte checks of `rsp_old` and `lw_be`. Requests offered while a response is stalled show whether the unit wrongly accepts a second operation.

// File: rtl/swap_pkg.sv
package swap_pkg;
   localparam int WORD_BYTES = 8;
   localparam int WORD_W     = 8 * WORD_BYTES;
   localparam int SIZE_W     = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_RESP = 2'd2
   } swap_state_e;

   typedef struct packed {
      logic              cond;
      logic [SIZE_W-1:0] size;
      logic [WORD_W-1:0] wdata;
      logic [WORD_W-1:0] cmp;
   } swap_op_t;
endpackage

// File: rtl/swap_extract.sv
module swap_extract
   import swap_pkg::*;
#(
   parameter int LINE_BYTES = 32,
   parameter int OFS_W      = $clog2(LINE_BYTES)
) (
   input  logic [8*LINE_BYTES-1:0] line,
   input  logic [OFS_W-1:0]        ofs,
   input  logic [SIZE_W-1:0]       size,
   output logic [WORD_W-1:0]       old_word
);
   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
      always_comb begin
         int idx;
         idx = int'(ofs) + k;
         old_word[8*k +: 8] = 8'h00;
         if ((k < int'(size)) && (idx < LINE_BYTES))
            old_word[8*k +: 8] = line[8*idx +: 8];
      end
   end
endmodule

// File: rtl/swap_check.sv
module swap_check
   import swap_pkg::*;
#(
   parameter int LINE_BYTES = 32,
   parameter int OFS_W      = $clog2(LINE_BYTES),
   parameter bit COND_EN    = 1'b1
) (
   input  logic              cond,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [SIZE_W-1:0] size,
   input  logic [WORD_W-1:0] old_word,
   input  logic [WORD_W-1:0] cmp,
   output logic              err,
   output logic              do_write
);
   logic size_ok, range_ok, cond_ok, match;

   always_comb begin
      size_ok  = (size != '0) && (int'(size) <= WORD_BYTES);
      range_ok = (int'(ofs) + int'(size)) <= LINE_BYTES;
      if (size == SIZE_W'(4))
         match = old_word[31:0] == cmp[31:0];
      else
         match = old_word == cmp;
   end

   if (COND_EN) begin : g_cond
      assign cond_ok = (size == SIZE_W'(4)) || (size == SIZE_W'(8));
   end else begin : g_nocond
      assign cond_ok = 1'b0;
   end

   assign err      = !size_ok || !range_ok || (cond && !cond_ok);
   assign do_write = !err && (!cond || match);
endmodule

// File: rtl/swap_merge.sv
module swap_merge
   import swap_pkg::*;
#(
   parameter int LINE_BYTES = 32,
   parameter int OFS_W      = $clog2(LINE_BYTES)
) (
   input  logic [8*LINE_BYTES-1:0] line,
   input  logic [OFS_W-1:0]        ofs,
   input  logic [SIZE_W-1:0]       size,
   input  logic [WORD_W-1:0]       wdata,
   input  logic                    en,
   output logic [8*LINE_BYTES-1:0] data,
   output logic [LINE_BYTES-1:0]   be
);
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
      always_comb begin
         int rel;
         rel = b - int'(ofs);
         be[b]          = 1'b0;
         data[8*b +: 8] = line[8*b +: 8];
         if (en && (rel >= 0) && (rel < int'(size)) && (rel < WORD_BYTES)) begin
            be[b]          = 1'b1;
            data[8*b +: 8] = wdata[8*rel +: 8];
         end
      end
   end
endmodule

// File: rtl/line_swap_unit.sv
module line_swap_unit
   import swap_pkg::*;
#(
   parameter int LINE_BYTES = 32,
   parameter bit COND_EN    = 1'b1,
   localparam int OFS_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = 8 * LINE_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_cond,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [3:0]        req_size,
   input  logic [63:0]       req_wdata,
   input  logic [63:0]       req_cmp,
   input  logic [LINE_W-1:0] req_line,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [63:0]       rsp_old,
   output logic              rsp_wrote,
   output logic              rsp_err,
   output logic              lw_en,
   output logic [LINE_BYTES-1:0] lw_be,
   output logic [LINE_W-1:0] lw_data,
   output logic              lw_mark_dirty
);
   if (LINE_BYTES < WORD_BYTES) begin : g_bad_len
      $error("line_swap_unit: LINE_BYTES must hold one full word");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_pow
      $error("line_swap_unit: LINE_BYTES must be a power of two");
   end

   swap_state_e       state_q;
   swap_op_t          op_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [LINE_W-1:0] line_q;
   logic [63:0]       old_q;
   logic              wrote_q, err_q;

   logic [63:0] old_word;
   logic        chk_err, chk_write, exec_write;

   swap_extract #(.LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W)) u_extract (
      .line     (line_q),
      .ofs      (ofs_q),
      .size     (op_q.size),
      .old_word (old_word)
   );

   swap_check #(.LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W), .COND_EN(COND_EN)) u_check (
      .cond     (op_q.cond),
      .ofs      (ofs_q),
      .size     (op_q.size),
      .old_word (old_word),
      .cmp      (op_q.cmp),
      .err      (chk_err),
      .do_write (chk_write)
   );

   assign exec_write = (state_q == ST_EXEC) && chk_write;

   swap_merge #(.LINE_BYTES(LINE_BYTES), .OFS_W(OFS_W)) u_merge (
      .line  (line_q),
      .ofs   (ofs_q),
      .size  (op_q.size),
      .wdata (op_q.wdata),
      .en    (exec_write),
      .data  (lw_data),
      .be    (lw_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         ofs_q   <= '0;
         line_q  <= '0;
         old_q   <= '0;
         wrote_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q.cond  <= req_cond;
                  op_q.size  <= req_size;
                  op_q.wdata <= req_wdata;
                  op_q.cmp   <= req_cmp;
                  ofs_q      <= req_offset;
                  line_q     <= req_line;
                  state_q    <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               old_q   <= chk_err ? '0 : old_word;
               err_q   <= chk_err;
               wrote_q <= chk_write;
               state_q <= ST_RESP;
            end
            ST_RESP: begin
               if (rsp_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_old       = old_q;
   assign rsp_wrote     = wrote_q;
   assign rsp_err       = err_q;
   assign lw_en         = exec_write;
   assign lw_mark_dirty = exec_write;
endmodule

// File: rtl/swap_checker.sv
module swap_checker #(
   parameter int LINE_BYTES = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic                  rsp_valid,
   input logic                  rsp_ready,
   input logic [63:0]           rsp_old,
   input logic                  rsp_wrote,
   input logic                  rsp_err,
   input logic                  lw_en,
   input logic [LINE_BYTES-1:0] lw_be,
   input logic                  lw_mark_dirty
);
   p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

   p_write_then_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lw_en |=> $rose(rsp_valid));

   p_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lw_en |-> (lw_be != '0));

   p_idle_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !lw_en |-> (lw_be == '0));

   p_wrote_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (rsp_wrote == $past(lw_en)));

   p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (!rsp_wrote && rsp_old == 64'h0));

   p_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lw_mark_dirty == lw_en);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old)
                                     && $stable(rsp_err) && $stable(rsp_wrote)));
endmodule

bind line_swap_unit swap_checker #(.LINE_BYTES(LINE_BYTES)) u_swap_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_ready     (rsp_ready),
   .rsp_old       (rsp_old),
   .rsp_wrote     (rsp_wrote),
   .rsp_err       (rsp_err),
   .lw_en         (lw_en),
   .lw_be         (lw_be),
   .lw_mark_dirty (lw_mark_dirty)
);

// File: tb/sim_line_swap_unit.sv
module sim_line_swap_unit;
   localparam int LB = 16;
   localparam int LW = 8 * LB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_cond = 1'b0;
   logic [3:0]    req_offset = '0;
   logic [3:0]    req_size = '0;
   logic [63:0]   req_wdata = '0;
   logic [63:0]   req_cmp = '0;
   logic [LW-1:0] req_line = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b0;
   logic [63:0]   rsp_old;
   logic          rsp_wrote, rsp_err;
   logic          lw_en;
   logic [LB-1:0] lw_be;
   logic [LW-1:0] lw_data;
   logic          lw_mark_dirty;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   line_swap_unit #(.LINE_BYTES(LB), .COND_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_cond(req_cond),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .req_cmp(req_cmp), .req_line(req_line),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old),
      .rsp_wrote(rsp_wrote), .rsp_err(rsp_err),
      .lw_en(lw_en), .lw_be(lw_be), .lw_data(lw_data), .lw_mark_dirty(lw_mark_dirty)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic run_op(input int ofs, input int size, input int mode, input int n);
      logic [LW-1:0] line, exp_data;
      logic [63:0]   raw, exp_old, wd, cmp;
      logic [LB-1:0] exp_be;
      bit cond, legal, match, wr;
      int hold;
      for (int b = 0; b < LB; b++) line[8*b +: 8] = 8'(b * 29 + n * 7 + 3);
      wd   = {32'hA5C3_1E0F ^ 32'(n), 32'h0F1E_2D3C + 32'(n)};
      cond = (mode != 0);
      raw  = '0;
      for (int k = 0; k < 8; k++)
         if (k < size && ofs + k < LB) raw[8*k +: 8] = line[8*(ofs+k) +: 8];
      cmp = raw;
      if (size == 4 && mode == 1) cmp[63:32] = 32'hDEAD_BEEF;
      if (mode == 2) cmp = raw ^ 64'h1;
      legal = (size >= 1) && (size <= 8) && (ofs + size <= LB)
              && (!cond || size == 4 || size == 8);
      match = (size == 4) ? (raw[31:0] == cmp[31:0]) : (raw == cmp);
      wr    = legal && (!cond || match);
      exp_old  = legal ? raw : 64'h0;
      exp_be   = '0;
      exp_data = line;
      if (wr)
         for (int b = ofs; b < ofs + size; b++) begin
            exp_be[b] = 1'b1;
            exp_data[8*b +: 8] = wd[8*(b-ofs) +: 8];
         end
      hold = (ofs + size + mode) % 3;

      req_valid = 1'b1; req_cond = cond; req_offset = 4'(ofs); req_size = 4'(size);
      req_wdata = wd; req_cmp = cmp; req_line = line;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      // write cycle
      check(lw_en == wr, $sformatf("R4/R5/R6/R7 lw_en o%0d s%0d m%0d", ofs, size, mode),
            LW'(lw_en), LW'(wr));
      check(lw_mark_dirty == wr, "R8 dirty strobe", LW'(lw_mark_dirty), LW'(wr));
      check(lw_be == exp_be, $sformatf("R4 lw_be o%0d s%0d m%0d", ofs, size, mode),
            LW'(lw_be), LW'(exp_be));
      if (wr) check(lw_data == exp_data, "R4 lw_data", lw_data, exp_data);
      check(!req_ready && !rsp_valid, "R2 busy after accept",
            LW'({req_ready, rsp_valid}), LW'(0));
      if (hold > 0) begin
         req_valid = 1'b1; req_size = 4'd8; req_offset = '0; req_cond = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid && !req_ready, "R2 response cycle", LW'({rsp_valid, req_ready}), LW'(2));
      check(rsp_old == exp_old, $sformatf("R3 old o%0d s%0d m%0d", ofs, size, mode),
            LW'(rsp_old), LW'(exp_old));
      check(rsp_err == !legal, $sformatf("R6/R7 err o%0d s%0d m%0d", ofs, size, mode),
            LW'(rsp_err), LW'(!legal));
      check(rsp_wrote == wr, "R5 wrote flag", LW'(rsp_wrote), LW'(wr));
      for (int h = 0; h < hold; h++) begin
         @(posedge clk);
         @(negedge clk);
         check(rsp_valid && rsp_old == exp_old && rsp_err == !legal && rsp_wrote == wr
               && !req_ready && !lw_en, "R9 hold under stall",
               LW'({rsp_valid, rsp_old}), LW'({1'b1, exp_old}));
      end
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rsp_ready = 1'b0;
      req_valid = 1'b0;
      check(req_ready && !rsp_valid && !lw_en, "R2 idle after response, stalled request not taken",
            LW'({req_ready, rsp_valid, lw_en}), LW'(3'b100));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_valid && !lw_en, "R1 reset state",
            LW'({req_ready, rsp_valid, lw_en}), LW'(3'b100));
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !lw_en, "R1 after reset release",
            LW'({req_ready, rsp_valid, lw_en}), LW'(3'b100));
      begin
         int n;
         n = 0;
         for (int o = 0; o < LB; o++)
            for (int s = 0; s < 10; s++)
               for (int m = 0; m < 3; m++) begin
                  run_op(o, s, m, n);
                  n++;
               end
      end
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end
endmodule